// File: doc/BRIEF.md
# Bank-Interleaved SDRAM Read Pattern Generator

This block drives a fixed, repeating SDRAM command stream of the kind used to load a memory for supply-current measurement. After `run` is raised, it steps through a schedule in which every slot is one clock. Each slot carries one command, either no-operation, activate, read or precharge. In single-bank mode it cycles activate, read and precharge on bank 0. In four-bank mode it rotates activates and auto-precharge reads across banks 0 to 3, with activates two clocks apart and each read three clocks after its own activate.

The schedule is picked from the `grade` and `quad_mode` inputs, which are latched at start. The 100 MHz grade runs shorter schedules than the two 133 MHz grades. Row and column addresses come from an internal 16-bit LFSR that advances on every activate, so the addresses differ from one repetition to the next. A `burst` flag marks the clocks in which read data would be on the bus for the latched CAS latency.

The FSM has three states. `ST_IDLE` goes to `ST_SINGLE` or `ST_QUAD` when `run` is sampled high, and the choice follows `quad_mode`. Each running state goes back to `ST_IDLE` when `run` is sampled low. Within a running state the slot counter wraps at the end of the period, and that wrap clears the first-pass flag.

Top module: `pg_read_patgen`

## Requirements
- R1: During reset and in idle, the command is deselect, `ba` is 0 and `addr` is 0. `burst` is low after reset.
- R2: The command is `{cs_n,ras_n,cas_n,we_n}`, encoded as deselect 1111, NOP 0111, activate 0011, read 0101 and precharge 0010.
- R3: In idle, a clock edge that samples `run` high latches `grade` and `quad_mode`. Slot 0, an activate, is driven in the next cycle. Changes to `grade` or `quad_mode` while the block is running have no effect.
- R4: In single-bank mode with `grade` 1, 2 or 3, the period is 9 slots: A N N R N P N N N, all on bank 0.
- R5: In single-bank mode with `grade` 0, the period is 7 slots: A N R N N P N, all on bank 0.
- R6: In four-bank mode with `grade` 1, 2 or 3, the period is 10 slots: A0 N A1 R0 A2 R1 A3 R2 N R3.
- R7: In four-bank mode with `grade` 0, the period is 8 slots: A0 x A1 R0 A2 R1 A3 R2. Slot x is a NOP in the first pass after start. In every later pass slot x is R3, which belongs to the previous pass.
- R8: The LFSR `s` is seeded 16'hACE1 at reset and steps as next = `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. On each activate `s` steps, the activate drives the new `s[12:0]` as its row, and the new `s` is stored for that bank.
- R9: A read drives `{stored[9:2], 2'b00}` of its bank on `addr[9:0]` and zeros on `addr[12:11]`. `addr[10]` is 1 in four-bank mode and 0 in single-bank mode. A precharge drives `addr` 0 and `ba` 0.
- R10: `burst` is high in clocks r+2 and r+3 after a read in clock r when `grade` < 2. It is high in clocks r+3 and r+4 when `grade` >= 2.
- R11: A clock edge that samples `run` low while running gives deselect in the next cycle. A later start restarts at slot 0 as a first pass.
- R12: Within a run, activates are at least 2 clocks apart. A read follows its bank's activate by 2 clocks in R5 and by 3 clocks otherwise. A single-bank precharge follows its activate by 5 clocks. Two activates to the same bank are one period apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to run the pattern, low to stop |
| quad_mode | input | 1 | 1 selects four-bank mode, latched at start |
| grade | input | 2 | Speed grade: 0 = 100 MHz CL2, 1 = 133 MHz CL2, 2/3 = 133 MHz CL2.5 |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Row address, or column address with the auto-precharge bit at bit 10 |
| burst | output | 1 | High while read data would be on the bus |

## Verification
The hardest state to reach is the four-bank 100 MHz wrap. There, slot 1 carries the previous pass's bank-3 read, but only after a full pass has been made since the most recent start. The stimulus runs that schedule for several passes. It then drops `run` partway through a pass and raises it again, so that the pending read is lost and the restarted first pass must show a NOP in slot 1. A separate window flips `grade` and `quad_mode` while a schedule is running, to show that the latched choice holds until the next start.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_QUAD   = 2'd2
    } pg_state_e;

    typedef enum logic [1:0] {
        SL_NOP = 2'd0,
        SL_ACT = 2'd1,
        SL_RD  = 2'd2,
        SL_PRE = 2'd3
    } pg_slot_e;

    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_ACT   = 4'b0011;
    localparam logic [3:0] CMD_RD    = 4'b0101;
    localparam logic [3:0] CMD_PRE   = 4'b0010;

    localparam int LFSR_W = 16;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/pg_slot_sched.sv
module pg_slot_sched
    import pg_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  pg_state_e         state,
    input  logic              fast,
    input  logic              first,
    input  logic [SLOT_W-1:0] slot,
    output pg_slot_e          kind,
    output logic [1:0]        bank,
    output logic              last
);
    logic [SLOT_W-1:0] period;

    always_comb begin
        kind   = SL_NOP;
        bank   = 2'd0;
        period = SLOT_W'(1);
        unique case (state)
            ST_SINGLE: begin
                period = fast ? SLOT_W'(7) : SLOT_W'(9);
                if (slot == '0)
                    kind = SL_ACT;
                else if (slot == (fast ? SLOT_W'(2) : SLOT_W'(3)))
                    kind = SL_RD;
                else if (slot == SLOT_W'(5))
                    kind = SL_PRE;
            end
            ST_QUAD: begin
                period = fast ? SLOT_W'(8) : SLOT_W'(10);
                if (slot < SLOT_W'(8) && !slot[0]) begin
                    kind = SL_ACT;
                    bank = slot[2:1];
                end else if (slot == SLOT_W'(3) || slot == SLOT_W'(5) || slot == SLOT_W'(7)) begin
                    kind = SL_RD;
                    bank = slot[2:1] - 2'd1;
                end else if ((slot == SLOT_W'(1) && fast && !first) || slot == SLOT_W'(9)) begin
                    kind = SL_RD;
                    bank = 2'd3;
                end
            end
            default: begin
                kind = SL_NOP;
            end
        endcase
    end

    assign last = (slot == period - SLOT_W'(1));
endmodule

// File: rtl/pg_addr_gen.sv
module pg_addr_gen
    import pg_pkg::*;
#(
    parameter int                ROW_W = 13,
    parameter int                COL_W = 10,
    parameter int                NBANK = 4,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     act_en,
    input  logic [$clog2(NBANK)-1:0] act_bank,
    input  logic [$clog2(NBANK)-1:0] rd_bank,
    output logic [ROW_W-1:0]         row_next,
    output logic [ROW_W-1:0]         col
);
    localparam int BW = $clog2(NBANK);

    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] nxt;
    logic [COL_W-3:0]  words [NBANK];

    assign nxt      = lfsr_step(lfsr);
    assign row_next = nxt[ROW_W-1:0];
    assign col      = ROW_W'({words[rd_bank], 2'b00});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= SEED;
            for (int b = 0; b < NBANK; b++) words[b] <= '0;
        end else if (act_en) begin
            lfsr <= nxt;
            for (int b = 0; b < NBANK; b++)
                if (act_bank == BW'(b)) words[b] <= nxt[COL_W-1:2];
        end
    end
endmodule

// File: rtl/pg_burst_track.sv
module pg_burst_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic cl3,
    output logic burst
);
    localparam int HIST = 4;

    logic [HIST-1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HIST-2:0], rd};
    end

    assign burst = cl3 ? (hist[2] | hist[3]) : (hist[1] | hist[2]);
endmodule

// File: rtl/pg_read_patgen.sv
module pg_read_patgen
    import pg_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10,
    parameter int SLOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             quad_mode,
    input  logic [1:0]       grade,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic             burst
);
    pg_state_e         state;
    logic [SLOT_W-1:0] slot;
    logic              first;
    logic              lat_fast;
    logic              lat_cl3;

    pg_slot_e          kind;
    logic [1:0]        bank;
    logic              last;
    logic [ROW_W-1:0]  row_next;
    logic [ROW_W-1:0]  col;
    logic [3:0]        cmd;
    logic              running;

    assign running = (state != ST_IDLE);

    pg_slot_sched #(.SLOT_W(SLOT_W)) i_sched (
        .state (state),
        .fast  (lat_fast),
        .first (first),
        .slot  (slot),
        .kind  (kind),
        .bank  (bank),
        .last  (last)
    );

    pg_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .NBANK(4)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (running && kind == SL_ACT),
        .act_bank (bank),
        .rd_bank  (bank),
        .row_next (row_next),
        .col      (col)
    );

    pg_burst_track i_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (running && kind == SL_RD),
        .cl3   (lat_cl3),
        .burst (burst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            slot     <= '0;
            first    <= 1'b1;
            lat_fast <= 1'b0;
            lat_cl3  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run) begin
                        state    <= quad_mode ? ST_QUAD : ST_SINGLE;
                        slot     <= '0;
                        first    <= 1'b1;
                        lat_fast <= (grade == 2'd0);
                        lat_cl3  <= grade[1];
                    end
                end
                ST_SINGLE, ST_QUAD: begin
                    if (!run) begin
                        state <= ST_IDLE;
                    end else if (last) begin
                        slot  <= '0;
                        first <= 1'b0;
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd  = CMD_DESEL;
        ba   = 2'd0;
        addr = '0;
        if (running) begin
            unique case (kind)
                SL_NOP: cmd = CMD_NOP;
                SL_ACT: begin
                    cmd  = CMD_ACT;
                    ba   = bank;
                    addr = row_next;
                end
                SL_RD: begin
                    cmd          = CMD_RD;
                    ba           = bank;
                    addr         = col;
                    addr[AP_BIT] = (state == ST_QUAD);
                end
                SL_PRE: cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/pg_read_patgen_chk.sv
module pg_read_patgen_chk
    import pg_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [1:0]       ba,
    input logic [ROW_W-1:0] addr,
    input pg_state_e        state
);
    logic [3:0] c;
    assign c = {cs_n, ras_n, cas_n, we_n};

    AST_STOP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> cs_n) else $error("stop not followed by deselect"); // R11

    AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n) |-> (c == CMD_NOP || c == CMD_ACT || c == CMD_RD || c == CMD_PRE))
        else $error("illegal command code"); // R2

    AST_START_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run) |=> (c == CMD_ACT)) else $error("start without activate"); // R3

    AST_QUAD_AP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAD && c == CMD_RD) |-> addr[AP_BIT]) else $error("quad read lacks AP"); // R9

    AST_SINGLE_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SINGLE && c == CMD_RD) |-> !addr[AP_BIT]) else $error("single read has AP"); // R9

    AST_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (c == CMD_PRE) |-> (addr == '0 && ba == 2'd0)) else $error("precharge address not zero"); // R9

    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (c == CMD_ACT) |=> (c != CMD_ACT)) else $error("activates adjacent"); // R12
endmodule

bind pg_read_patgen pg_read_patgen_chk #(.ROW_W(ROW_W), .AP_BIT(AP_BIT)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .state (state)
);

// File: tb/test_pg_read_patgen.sv
module test_pg_read_patgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        quad_mode = 1'b0;
    logic [1:0]  grade = 2'd1;
    logic        cs_n, ras_n, cas_n, we_n, burst;
    logic [1:0]  ba;
    logic [12:0] addr;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string phase_tag = "";

    always #5 clk = ~clk;

    pg_read_patgen i_pg_read_patgen (
        .clk(clk), .rst_n(rst_n), .run(run), .quad_mode(quad_mode), .grade(grade),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .burst(burst)
    );

    // reference model state: 0 idle, 1 single, 2 quad
    int          m_state = 0;
    int          m_slot = 0;
    bit          m_first = 1'b1;
    bit          m_fast = 1'b0;
    bit          m_cl3 = 1'b0;
    logic [15:0] m_lfsr = 16'hACE1;
    logic [15:0] m_word [4] = '{default: 16'h0};
    logic [3:0]  m_hist = 4'h0;

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic string sched();
        if (m_state == 1) return m_fast ? "A0NNR0NNNNP0NN" : "A0NNNNR0NNP0NNNNNN";
        return m_fast ? "A0R3A1R0A2R1A3R2" : "A0NNA1R0A2R1A3R2NNR3";
    endfunction

    function automatic string tok();
        string s;
        if (m_state == 0) return "DS";
        if (m_state == 2 && m_fast && m_first && m_slot == 1) return "NN";
        s = sched();
        return s.substr(2 * m_slot, 2 * m_slot + 1);
    endfunction

    function automatic string mtag();
        if (m_state == 0) return {phase_tag, " R1"};
        if (m_state == 1) return m_fast ? {phase_tag, " R5"} : {phase_tag, " R4"};
        return m_fast ? {phase_tag, " R7"} : {phase_tag, " R6"};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // model update, mirrors the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_slot = 0; m_first = 1; m_fast = 0; m_cl3 = 0;
            m_lfsr = 16'hACE1; m_hist = 4'h0;
            for (int b = 0; b < 4; b++) m_word[b] = 16'h0;
        end else begin
            string t;
            string s;
            t = tok();
            if (t[0] == "A") begin
                m_lfsr = step(m_lfsr);
                m_word[t[1] - 8'h30] = m_lfsr;
            end
            m_hist = {m_hist[2:0], (t[0] == "R")};
            if (m_state == 0) begin
                if (run) begin
                    m_state = quad_mode ? 2 : 1;
                    m_slot = 0; m_first = 1;
                    m_fast = (grade == 2'd0);
                    m_cl3 = grade[1];
                end
            end else if (!run) begin
                m_state = 0;
            end else begin
                s = sched();
                if (m_slot == s.len() / 2 - 1) begin
                    m_slot = 0; m_first = 0;
                end else m_slot++;
            end
        end
    end

    // per-cycle comparison and spacing decode
    int ncyc = 0;
    int last_any = -1;
    int last_act [4] = '{default: -1};

    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            string s;
            logic [3:0] ecmd;
            int eba, eaddr, b, period, trcd;
            bit eburst;
            ncyc++;
            t = tok();
            eba = 0; eaddr = 0;
            case (t[0])
                "D": ecmd = 4'b1111;
                "N": ecmd = 4'b0111;
                "A": begin
                    ecmd = 4'b0011; eba = t[1] - 8'h30;
                    eaddr = int'(step(m_lfsr) & 16'h1FFF);
                end
                "R": begin
                    ecmd = 4'b0101; eba = t[1] - 8'h30;
                    eaddr = int'(m_word[eba] & 16'h03FC) | ((m_state == 2) ? 1024 : 0);
                end
                default: ecmd = 4'b0010;
            endcase
            eburst = m_cl3 ? (m_hist[2] | m_hist[3]) : (m_hist[1] | m_hist[2]);
            chk({cs_n, ras_n, cas_n, we_n} == ecmd, {"R2", mtag()}, "command",
                int'({cs_n, ras_n, cas_n, we_n}), int'(ecmd));
            chk(int'(ba) == eba, mtag(), "bank", int'(ba), eba);
            chk(int'(addr) == eaddr, (t[0] == "R") ? "R9" : ((t[0] == "A") ? "R8" : "R9"),
                "address", int'(addr), eaddr);
            chk(burst == eburst, "R10", "burst", int'(burst), int'(eburst));

            // spacing, decoded from the ports (R12)
            if (m_state != 0) begin
                s = sched();
                period = s.len() / 2;
            end else period = 0;
            trcd = (m_state == 1 && m_fast) ? 2 : 3;
            b = int'(ba);
            if (cs_n) begin
                last_any = -1;
                for (int k = 0; k < 4; k++) last_act[k] = -1;
            end else if ({ras_n, cas_n, we_n} == 3'b011) begin
                if (last_any >= 0)
                    chk(ncyc - last_any >= 2, "R12", "act-to-act gap", ncyc - last_any, 2);
                if (last_act[b] >= 0)
                    chk(ncyc - last_act[b] == period, "R12", "row cycle", ncyc - last_act[b], period);
                last_any = ncyc;
                last_act[b] = ncyc;
            end else if ({ras_n, cas_n, we_n} == 3'b101) begin
                chk(last_act[b] >= 0 && ncyc - last_act[b] == trcd, "R12", "act-to-read",
                    ncyc - last_act[b], trcd);
            end else if ({ras_n, cas_n, we_n} == 3'b010) begin
                chk(last_act[0] >= 0 && ncyc - last_act[0] == 5, "R12", "act-to-precharge",
                    ncyc - last_act[0], 5);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input bit q, input logic [1:0] g);
        quad_mode = q; grade = g; run = 1'b1;
        @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0011, "R3", "first slot activate",
            int'({cs_n, ras_n, cas_n, we_n}), 4'b0011);
    endtask

    task automatic stop(input int idle);
        run = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R11", "deselect after stop", int'(cs_n), 1);
        cycles(idle);
    endtask

    initial begin
        cycles(3);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "reset command",
            int'({cs_n, ras_n, cas_n, we_n}), 4'hF);
        chk(ba == 2'd0 && addr == 13'd0, "R1", "reset address", int'(addr), 0);
        chk(burst == 1'b0, "R1", "reset burst", int'(burst), 0);
        rst_n = 1'b1;
        cycles(4);

        start(1'b0, 2'd1); cycles(30);
        phase_tag = "R3";
        grade = 2'd0; quad_mode = 1'b1; cycles(20);
        phase_tag = "";
        stop(3);
        start(1'b0, 2'd0); cycles(25); stop(5);
        start(1'b1, 2'd1); cycles(40); stop(5);
        start(1'b1, 2'd2); cycles(40); stop(6);
        start(1'b1, 2'd0); cycles(45);
        phase_tag = "R11";
        stop(0);
        start(1'b1, 2'd0); cycles(30);
        stop(2);
        start(1'b0, 2'd2); cycles(20); stop(8);
        phase_tag = "";

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule